// File: doc/BRIEF.md
# Stereo Line Buffer Window Feeder

This block sits in front of a block-matching stereo engine. It takes a rectified image pair as a raster stream, with one 8-bit right-image pixel and one 8-bit left-image pixel per transfer. It stores the last image rows of each image in a rotating set of five line memories, and each memory holds up to 2048 pixels. For every accepted pixel pair it builds one 5-pixel column per image. The right-image column goes into a 5×5 reference window. The left-image column goes into a 5-row by 68-column candidate strip, which holds all 64 shifted 5×5 candidate windows side by side, so a downstream array of absolute-difference adders can score every disparity in the same cycle.

The active row width is captured from a configuration input at each start of frame. The first pixel of a frame is marked by a sideband flag that travels with the data. The block does not pad the image borders. Instead, every output beat carries a flag that says whether the window contents come completely from real pixels of the current frame.

Both stream edges use valid/ready. An input transfer happens on a cycle where `in_valid` and `in_ready` are both high. An output beat is consumed on a cycle where `out_valid` and `out_ready` are both high. The block holds at most one beat in flight behind its output. `in_ready` is high exactly when the output register is empty or is being consumed. A stall at the output therefore stops intake immediately, and no pixel is lost.

Top module: `stereo_window_feeder`

## Requirements
- R1: After reset, `out_valid` and `out_ok` are low and `in_ready` is high. `in_ready` is high whenever `out_valid` is low or `out_ready` is high. Each accepted pixel pair produces exactly one output beat, and beats leave in acceptance order.
- R2: When the output is free, a pixel pair accepted at clock edge k is presented as a beat right after edge k+1. With `out_ready` held high, `out_valid` is therefore still low one cycle after the first acceptance and high one cycle later.
- R3: For a beat of pixel (row r, column c), the reference window holds the right-image pixel of row r-4+q and column c-k. This element sits at bits [(q*5+k)*8 +: 8] of `ref_win`, for q and k in 0..4. Row index q=0 is the oldest row and column index k=0 is the newest column.
- R4: For the same beat, the candidate strip holds the left-image pixel of row r-4+q and column c-k at bits [(q*68+k)*8 +: 8] of `cand_win`, for q in 0..4 and k in 0..67. Candidate window d (0..63) consists of strip columns k=d..d+4.
- R5: `out_ok` is high on a beat exactly when r ≥ 4 and c ≥ 67, with rows and columns counted from 0 at the start of frame. When `out_ok` is high, every element named in R3 and R4 belongs to the current frame.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_ok`, `ref_win` and `cand_win` all hold their values.
- R7: A pixel pair accepted with `in_sof` high is row 0, column 0. It restarts row counting and the line-memory rotation, including after a frame that was cut short.
- R8: The row width is taken from `cfg_width` only on the start-of-frame transfer. Changes to `cfg_width` at any other time do not affect the row and column coordinates or `out_ok`.
- R9: A `cfg_width` of 0, or any value above 2048, is treated as 2048. Rows wrap after exactly that many pixels, and a 2048-pixel width is supported.
- R10: The five line memories rotate row by row, and the newest row overwrites the oldest one. Windows stay correct for rows beyond the fifth and for widths down to one pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | 12 | Row width in pixels, sampled on the start-of-frame transfer |
| in_valid | input | 1 | Input pixel pair valid |
| in_ready | output | 1 | Block can accept a pixel pair this cycle |
| in_sof | input | 1 | Marks the first pixel pair of a frame |
| in_right | input | 8 | Right-image (reference) pixel |
| in_left | input | 8 | Left-image (candidate) pixel |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_ok | output | 1 | Window contents come completely from the current frame |
| ref_win | output | 200 | 5×5 reference window, layout as in R3 |
| cand_win | output | 2720 | 5×68 candidate strip, layout as in R4 |

## Verification
Every output beat is due one clock edge after the cycle in which the pipeline stage ahead of it advances. An accepted pixel reaches the output right after the second edge from its acceptance when nothing stalls. The bench checks this once directly at the start of the stream, with both handshakes forced high, by sampling `out_valid` one and two cycles after the first acceptance. Everywhere else the back-pressure is random. For that reason the bench does not count cycles. It matches each consumed beat against a queue of accepted coordinates, and it samples every handshake between clock edges, where the transfer that the next edge makes is already decided. After a stalled cycle it checks that the output held.

// File: rtl/stw_pkg.sv
`timescale 1ns/1ps
package stw_pkg;
  // Modular add used for the line-memory rotation pointer.
  function automatic int unsigned rot_add(int unsigned base, int unsigned off, int unsigned n);
    return (base + off) % n;
  endfunction
endpackage

// File: rtl/stw_raster_ctrl.sv
`timescale 1ns/1ps
module stw_raster_ctrl #(
  parameter int MAX_W = 2048,
  parameter int NROW  = 5,
  parameter int SPAN  = 68,
  localparam int AW   = $clog2(MAX_W),
  localparam int WW   = AW + 1,
  localparam int PTRW = $clog2(NROW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  logic            sof,
  input  logic [WW-1:0]   cfg_width,
  output logic [AW-1:0]   addr,
  output logic [PTRW-1:0] wsel,
  output logic            win_ok
);
  import stw_pkg::*;

  logic [AW-1:0]   col_q, cur_col;
  logic [WW-1:0]   width_q, cur_w, cfg_eff;
  logic [PTRW-1:0] row_q, cur_row, ptr_q, cur_ptr;
  logic            last;

  always_comb begin
    cfg_eff = (cfg_width == '0 || cfg_width > WW'(MAX_W)) ? WW'(MAX_W) : cfg_width;
    cur_col = sof ? '0 : col_q;
    cur_row = sof ? '0 : row_q;
    cur_ptr = sof ? '0 : ptr_q;
    cur_w   = sof ? cfg_eff : width_q;
    last    = ({1'b0, cur_col} >= (cur_w - WW'(1)));
  end

  assign addr   = cur_col;
  assign wsel   = cur_ptr;
  assign win_ok = (cur_row == PTRW'(NROW - 1)) && (cur_col >= AW'(SPAN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q   <= '0;
      row_q   <= '0;
      ptr_q   <= '0;
      width_q <= WW'(MAX_W);
    end else if (acc) begin
      width_q <= cur_w;
      if (last) begin
        col_q <= '0;
        row_q <= (cur_row == PTRW'(NROW - 1)) ? cur_row : cur_row + PTRW'(1);
        ptr_q <= PTRW'(rot_add(32'(cur_ptr), 1, NROW));
      end else begin
        col_q <= cur_col + AW'(1);
        row_q <= cur_row;
        ptr_q <= cur_ptr;
      end
    end
  end

  // R7: a start-of-frame transfer restarts coordinates and rotation
  a_r7_sof_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sof && cfg_eff > WW'(1)) |=> (col_q == AW'(1) && row_q == '0 && ptr_q == '0));
  // R8: the captured width is kept between frame starts
  a_r8_width_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !sof) |=> $stable(width_q));
  // R9: the column never reaches the captured width
  a_r9_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, col_q} < width_q));
  // R10: the rotation pointer stays on an existing memory
  a_r10_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q < PTRW'(NROW)));
endmodule

// File: rtl/stw_line_store.sv
`timescale 1ns/1ps
module stw_line_store #(
  parameter int PW    = 8,
  parameter int NROW  = 5,
  parameter int MAX_W = 2048,
  localparam int AW   = $clog2(MAX_W),
  localparam int PTRW = $clog2(NROW)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [PTRW-1:0]    wsel,
  input  logic [PW-1:0]      din,
  output logic [NROW*PW-1:0] col_out
);
  import stw_pkg::*;

  logic [NROW*PW-1:0] rd_flat;
  logic [PTRW-1:0]    sel_q;
  logic [PW-1:0]      pix_q;

  for (genvar m = 0; m < NROW; m++) begin : g_mem
    logic [PW-1:0] ram [MAX_W];
    logic [PW-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (en) begin
        if (we && wsel == PTRW'(m)) ram[addr] <= din;
        rd_q <= ram[addr];
      end
    end
    assign rd_flat[m*PW +: PW] = rd_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      pix_q <= '0;
    end else if (en) begin
      sel_q <= wsel;
      pix_q <= din;
    end
  end

  // Row 0 is the oldest stored row; the newest row bypasses the memory.
  always_comb begin
    col_out = '0;
    for (int q = 0; q < NROW - 1; q++) begin
      col_out[q*PW +: PW] =
        rd_flat[int'(rot_add(32'(sel_q), 32'(q + 1), NROW))*PW +: PW];
    end
    col_out[(NROW-1)*PW +: PW] = pix_q;
  end
endmodule

// File: rtl/stw_shift_win.sv
`timescale 1ns/1ps
module stw_shift_win #(
  parameter int PW   = 8,
  parameter int NROW = 5,
  parameter int NCOL = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [NROW*PW-1:0]      col_in,
  output logic [NROW*NCOL*PW-1:0] win
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win <= '0;
    end else if (en) begin
      for (int q = 0; q < NROW; q++) begin
        win[(q*NCOL)*PW +: PW] <= col_in[q*PW +: PW];
        for (int k = 1; k < NCOL; k++) begin
          win[(q*NCOL+k)*PW +: PW] <= win[(q*NCOL+k-1)*PW +: PW];
        end
      end
    end
  end
endmodule

// File: rtl/stereo_window_feeder.sv
`timescale 1ns/1ps
module stereo_window_feeder #(
  parameter int PW       = 8,
  parameter int NROW     = 5,
  parameter int MAX_W    = 2048,
  parameter int REF_COLS = 5,
  parameter int SPAN     = 68,
  localparam int AW      = $clog2(MAX_W),
  localparam int WW      = AW + 1,
  localparam int PTRW    = $clog2(NROW)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WW-1:0]               cfg_width,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic                        in_sof,
  input  logic [PW-1:0]               in_right,
  input  logic [PW-1:0]               in_left,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic                        out_ok,
  output logic [NROW*REF_COLS*PW-1:0] ref_win,
  output logic [NROW*SPAN*PW-1:0]     cand_win
);
  logic            adv, acc;
  logic [AW-1:0]   addr;
  logic [PTRW-1:0] wsel;
  logic            pos_ok;
  logic            s1_v, s1_ok;
  logic [NROW*PW-1:0] col_r, col_l;

  assign adv      = !out_valid || out_ready;
  assign acc      = in_valid && adv;
  assign in_ready = adv;

  stw_raster_ctrl #(.MAX_W(MAX_W), .NROW(NROW), .SPAN(SPAN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sof(in_sof), .cfg_width(cfg_width),
    .addr(addr), .wsel(wsel), .win_ok(pos_ok));

  stw_line_store #(.PW(PW), .NROW(NROW), .MAX_W(MAX_W)) u_store_r (
    .clk(clk), .rst_n(rst_n), .en(adv), .we(acc), .addr(addr), .wsel(wsel),
    .din(in_right), .col_out(col_r));

  stw_line_store #(.PW(PW), .NROW(NROW), .MAX_W(MAX_W)) u_store_l (
    .clk(clk), .rst_n(rst_n), .en(adv), .we(acc), .addr(addr), .wsel(wsel),
    .din(in_left), .col_out(col_l));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s1_ok     <= 1'b0;
      out_valid <= 1'b0;
      out_ok    <= 1'b0;
    end else if (adv) begin
      s1_v      <= acc;
      s1_ok     <= pos_ok;
      out_valid <= s1_v;
      out_ok    <= s1_v && s1_ok;
    end
  end

  stw_shift_win #(.PW(PW), .NROW(NROW), .NCOL(REF_COLS)) u_ref (
    .clk(clk), .rst_n(rst_n), .en(adv && s1_v), .col_in(col_r), .win(ref_win));

  stw_shift_win #(.PW(PW), .NROW(NROW), .NCOL(SPAN)) u_cand (
    .clk(clk), .rst_n(rst_n), .en(adv && s1_v), .col_in(col_l), .win(cand_win));

  // R6: a stalled beat holds every output field
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_ok) && $stable(ref_win) && $stable(cand_win)));
  // R5: the border flag only rides on a valid beat
  a_r5_ok_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_ok |-> out_valid);
  // R1: a stalled output stops intake
  a_r1_no_intake_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/sim_stereo_window_feeder.sv
`timescale 1ns/1ps
module sim_stereo_window_feeder;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [11:0]  cfg_width = 12'd0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_sof = 1'b0;
  logic [7:0]   in_right = 8'd0;
  logic [7:0]   in_left = 8'd0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic         out_ok;
  logic [199:0]  ref_win;
  logic [2719:0] cand_win;

  stereo_window_feeder u0 (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .in_valid(in_valid),
    .in_ready(in_ready), .in_sof(in_sof), .in_right(in_right), .in_left(in_left),
    .out_valid(out_valid), .out_ready(out_ready), .out_ok(out_ok),
    .ref_win(ref_win), .cand_win(cand_win));

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int qf [0:32767];
  int qr [0:32767];
  int qc [0:32767];
  int wr_i = 0;
  int rd_i = 0;
  int it = 0;
  bit accepted = 1'b0;
  bit prev_stall = 1'b0;
  logic [199:0]  pref;
  logic [2719:0] pcand;
  logic          pok;
  logic [15:0]   lfsr = 16'hACE1;

  function automatic logic [7:0] pr(int f, int r, int c);
    return 8'((f*37 + r*11 + c*3 + 5) & 255);
  endfunction
  function automatic logic [7:0] pl(int f, int r, int c);
    return 8'((f*53 + r*29 + c*7 + 101) & 255);
  endfunction

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic chk_out();
    if (prev_stall) begin
      n_chk++;
      if (!(out_valid && out_ok == pok && ref_win == pref && cand_win == pcand)) begin
        n_fail++;
        $display("FAIL R6 stalled beat changed: valid=%0b ok=%0b expected valid=1 ok=%0b",
                 out_valid, out_ok, pok);
      end
    end
    if (out_valid && out_ready) begin
      if (rd_i >= wr_i) begin
        n_chk++; n_fail++;
        $display("FAIL R1 beat without accepted pixel: beats=%0d expected<=%0d", rd_i + 1, wr_i);
      end else begin
        int f, r, c;
        bit exp_ok;
        f = qf[rd_i]; r = qr[rd_i]; c = qc[rd_i];
        exp_ok = (r >= 4) && (c >= 67);
        n_chk++;
        if (out_ok !== exp_ok) begin
          n_fail++;
          $display("FAIL R5 ok flag at f%0d r%0d c%0d: got %0b expected %0b", f, r, c, out_ok, exp_ok);
        end
        if (exp_ok) begin
          bit bad_r, bad_l;
          logic [7:0] ga, ge, la, le;
          bad_r = 0; bad_l = 0; ga = 0; ge = 0; la = 0; le = 0;
          for (int q = 0; q < 5; q++) begin
            for (int k = 0; k < 5; k++) begin
              if (!bad_r && ref_win[(q*5+k)*8 +: 8] !== pr(f, r-4+q, c-k)) begin
                bad_r = 1; ga = ref_win[(q*5+k)*8 +: 8]; ge = pr(f, r-4+q, c-k);
              end
            end
            for (int k = 0; k < 68; k++) begin
              if (!bad_l && cand_win[(q*68+k)*8 +: 8] !== pl(f, r-4+q, c-k)) begin
                bad_l = 1; la = cand_win[(q*68+k)*8 +: 8]; le = pl(f, r-4+q, c-k);
              end
            end
          end
          n_chk++;
          if (bad_r) begin
            n_fail++;
            $display("FAIL R3 R10 reference window at f%0d r%0d c%0d: got %0d expected %0d", f, r, c, ga, ge);
          end
          n_chk++;
          if (bad_l) begin
            n_fail++;
            $display("FAIL R4 R10 candidate strip at f%0d r%0d c%0d: got %0d expected %0d", f, r, c, la, le);
          end
        end
        rd_i++;
      end
    end
    prev_stall = out_valid && !out_ready;
    pref = ref_win; pcand = cand_win; pok = out_ok;
  endtask

  // Sends npx pixel pairs of frame f; row width weff, cfg_width wcfg on the
  // start-of-frame pair and alt afterwards (R8).
  task automatic send_seg(int f, int wcfg, int weff, int npx, int alt);
    int pidx;
    pidx = 0;
    while (pidx < npx) begin
      @(negedge clk);
      step_lfsr();
      if (accepted) begin in_valid = 1'b0; accepted = 1'b0; end
      out_ready = (it < 3) ? 1'b1 : (lfsr[0] | lfsr[3]);
      if (!in_valid && ((it < 3) || lfsr[5] | lfsr[8])) begin
        in_valid  = 1'b1;
        in_sof    = (pidx == 0);
        cfg_width = (pidx == 0) ? 12'(wcfg) : 12'(alt);
        in_right  = pr(f, pidx / weff, pidx % weff);
        in_left   = pl(f, pidx / weff, pidx % weff);
      end
      #1;
      if (it == 1) begin
        n_chk++;
        if (out_valid !== 1'b0) begin
          n_fail++; $display("FAIL R2 beat too early: out_valid=%0b expected 0", out_valid);
        end
      end
      if (it == 2) begin
        n_chk++;
        if (out_valid !== 1'b1) begin
          n_fail++; $display("FAIL R2 beat missing: out_valid=%0b expected 1", out_valid);
        end
      end
      chk_out();
      if (in_valid && in_ready) begin
        qf[wr_i] = f; qr[wr_i] = pidx / weff; qc[wr_i] = pidx % weff;
        wr_i++; pidx++; accepted = 1'b1;
      end
      it++;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    n_chk++;
    if (out_valid !== 1'b0) begin n_fail++; $display("FAIL R1 reset out_valid=%0b expected 0", out_valid); end
    n_chk++;
    if (out_ok !== 1'b0) begin n_fail++; $display("FAIL R1 reset out_ok=%0b expected 0", out_ok); end
    n_chk++;
    if (in_ready !== 1'b1) begin n_fail++; $display("FAIL R1 reset in_ready=%0b expected 1", in_ready); end

    send_seg(0, 70, 70, 70*7, 70);          // R3 R4 R10: rows past the fifth
    send_seg(1, 72, 72, 72*3 + 30, 72);     // frame cut short
    send_seg(2, 68, 68, 68*5, 5);           // R7 restart, R8 mid-frame width ignored
    send_seg(3, 0, 2048, 2048*5, 0);        // R9 width 0 means 2048
    send_seg(4, 1, 1, 9, 1);                // R10 one-pixel rows
    send_seg(5, 4000, 2048, 2048*4 + 100, 4000); // R9 oversize width clamps

    for (int d = 0; d < 64 && rd_i < wr_i; d++) begin
      @(negedge clk);
      if (accepted) begin in_valid = 1'b0; accepted = 1'b0; end
      out_ready = 1'b1;
      #1;
      chk_out();
    end
    n_chk++;
    if (rd_i != wr_i) begin
      n_fail++; $display("FAIL R1 beats delivered=%0d expected %0d", rd_i, wr_i);
    end
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: beats=%0d expected %0d", rd_i, wr_i);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule